// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

A per-processor interval timer. A cycle counter starts from zero at reset and advances by one on every clock. One register address reaches two registers. A read strobe returns the counter. A write strobe loads a compare register, which cannot be read back. When the low compare-width bits of the counter equal the compare value, the block records a pending interrupt. The pending interrupt stays set until software acknowledges it. A mask input can hold the interrupt line low without losing the pending record.

The counter width is a parameter, normally 32 or 64. The compare width defaults to 32, and only that many low counter bits take part in the match. Software keeps a periodic tick by writing "counter plus period" into the compare register from its interrupt handler. If the value written is already behind the counter, the interrupt comes only after the low bits wrap back around to it.

The pending logic is a three-state machine with the states `ST_DISARMED`, `ST_ARMED` and `ST_PENDING`:
- **Arm** (`ST_DISARMED` to `ST_ARMED`): taken on the first compare write.
- **Hit** (`ST_ARMED` to `ST_PENDING`): taken on a match.
- **Clear** (`ST_PENDING` to `ST_ARMED`): taken on an acknowledge with no match in the same cycle.

In every other case the machine holds its state.

Top module: `ivt_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the counter reads 0 and `irq_o` is 0.
- R2: The counter increases by exactly one per clock cycle and wraps modulo 2^CNT_W.
- R3: While `reg_rd_i` is 1, `reg_rdata_o` shows the current counter value. While `reg_rd_i` is 0, `reg_rdata_o` is 0.
- R4: After reset and before the first compare write, no interrupt is recorded, even when the counter's low bits pass the reset compare value of 0.
- R5: A write (`reg_wr_i` = 1) loads `reg_wdata_i` into the compare register at the clock edge. If the counter's low CMP_W bits equal the compare value in cycle t, the pending flag is set and `irq_o` (when unmasked) is 1 from cycle t+1.
- R6: Only the low CMP_W counter bits are matched. A compare value equal to the counter's low bits at the moment of the write produces no interrupt until 2^CMP_W cycles later.
- R7: While `irq_mask_i` is 1, `irq_o` is 0 but the pending flag is kept. Clearing the mask makes `irq_o` 1 in the same cycle.
- R8: `irq_ack_i` = 1 clears the pending flag at the next edge. A match in the same cycle as the acknowledge wins, and the flag stays set. An acknowledge with nothing pending has no effect.
- R9: A compare write in the same cycle as a match still records that match against the old compare value.
- R10: A compare write while an interrupt is pending does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_rd_i | input | 1 | Read strobe; returns the counter |
| reg_wr_i | input | 1 | Write strobe; loads the compare register |
| reg_wdata_i | input | CMP_W | Compare value to write |
| reg_rdata_o | output | CNT_W | Counter value while reading, else 0 |
| irq_mask_i | input | 1 | 1 = interrupt output held low |
| irq_ack_i | input | 1 | 1 = clear the pending interrupt |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or skipping counter shows at the read port within one read, because two reads some known number of cycles apart must differ by exactly that number. A state machine that leaves `ST_DISARMED` early, or drops `ST_PENDING`, shows at `irq_o` within one cycle of the matching count, acknowledge or write. The bench therefore samples `irq_o` on the cycle before and the cycle of each expected rise. A match taken against the wrong bit slice only shows after a wrap of the compare width, so the bench uses a narrow compare width and runs past a full wrap.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_PENDING  = 2'd2
    } pend_state_e;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2: one count per clock, modulo wrap
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/ivt_compare.sv
module ivt_compare #(
    parameter int CMP_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CMP_W-1:0] wdata_i,
    input  logic [CMP_W-1:0] cnt_low_i,
    output logic             match_o
);
    logic [CMP_W-1:0] cmp_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)   cmp_q <= '0;
        else if (wr_i) cmp_q <= wdata_i;
    end

    // The match uses the compare value held before this edge, so a
    // write in the matching cycle does not hide the match (R9).
    assign match_o = (cnt_low_i == cmp_q);

    // R5: a write loads the compare register
    a_r5_cmp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> cmp_q == $past(wdata_i));
endmodule

// File: rtl/ivt_pend_fsm.sv
module ivt_pend_fsm
    import ivt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic match_i,
    input  logic ack_i,
    input  logic mask_i,
    output logic irq_o
);
    pend_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_DISARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (wr_i)              state_d = ST_ARMED;
            ST_ARMED:    if (match_i)           state_d = ST_PENDING;
            ST_PENDING:  if (ack_i && !match_i) state_d = ST_ARMED;
            default:                            state_d = ST_DISARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_PENDING) && !mask_i;
    end

    // R4: only a write arms the machine
    a_r4_stay_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DISARMED && !wr_i) |=> state_q == ST_DISARMED);
    a_r4_write_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DISARMED && wr_i) |=> state_q == ST_ARMED);
    // R5: a match while armed records the interrupt
    a_r5_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED && match_i) |=> state_q == ST_PENDING);
    // R8: an acknowledge without a match clears it
    a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PENDING && ack_i && !match_i) |=> state_q == ST_ARMED);
    // R10: pending holds without an acknowledge
    a_r10_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PENDING && !ack_i) |=> state_q == ST_PENDING);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic [CMP_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    input  logic             irq_mask_i,
    input  logic             irq_ack_i,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt;
    logic             match;

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt)
    );

    ivt_compare #(.CMP_W(CMP_W)) u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .cnt_low_i (cnt[CMP_W-1:0]),
        .match_o   (match)
    );

    ivt_pend_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .match_i (match),
        .ack_i   (irq_ack_i),
        .mask_i  (irq_mask_i),
        .irq_o   (irq_o)
    );

    assign reg_rdata_o = reg_rd_i ? cnt : '0;

    // R7: a set mask keeps the line low
    a_r7_mask_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_mask_i |-> !irq_o);
endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
    localparam int CNT_W = 12;
    localparam int CMP_W = 8;
    localparam int NVEC  = 5;
    // {offset[7:0], mask, expect_fire}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'd1,  1'b0, 1'b1},
        {8'd5,  1'b0, 1'b1},
        {8'd3,  1'b1, 1'b1},
        {8'd20, 1'b0, 1'b1},
        {8'd0,  1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd = 1'b0, wr = 1'b0, mask = 1'b0, ack = 1'b0;
    logic [CMP_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             irq;
    int               checks = 0, errors = 0;
    bit               done = 1'b0;

    always #4 clk = ~clk;

    ivt_timer #(.CNT_W(CNT_W), .CMP_W(CMP_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_mask_i(mask),
        .irq_ack_i(ack), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // read the counter now and write (counter + off) as compare
    task automatic wr_rel(input int off);
        logic [CNT_W-1:0] c;
        rd = 1'b1;
        #1;
        c = rdata;
        rd = 1'b0;
        wr = 1'b1;
        wdata = CMP_W'(c + CNT_W'(off));
        step();
        wr = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] c0;
        bit               seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        rd = 1'b1;
        #1;
        chk("R1 counter in reset", 32'(rdata), 0);
        chk("R1 irq in reset", 32'(irq), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 counter after release", 32'(rdata), 0);
        // R2: one count per clock
        repeat (5) step();
        #1;
        chk("R2 counter after 5", 32'(rdata), 5);
        c0 = rdata;
        repeat (37) step();
        #1;
        chk("R2 counter step", 32'(rdata - c0), 37);
        // R3: no read, zero data
        rd = 1'b0;
        #1;
        chk("R3 rdata idle", 32'(rdata), 0);
        // R4: no interrupt before the first write, across a low-bit wrap
        seen = 1'b0;
        ack = 1'b1;
        repeat (300) begin
            step();
            if (irq) seen = 1'b1;
        end
        ack = 1'b0;
        chk("R4 disarmed quiet", 32'(seen), 0);

        // vector table: R5 / R7 / R8 / R6
        for (int i = 0; i < NVEC; i++) begin
            int  k;
            bit  m, f;
            k = int'(VEC[i][9:2]);
            m = VEC[i][1];
            f = VEC[i][0];
            mask = m;
            wr_rel(k);
            if (k > 1) repeat (k - 1) step();
            chk("R5 irq before match", 32'(irq), 0);
            step();
            chk("R5 irq after match", 32'(irq), 32'(f && !m));
            if (m) begin
                mask = 1'b0;
                #1;
                chk("R7 unmask shows pending", 32'(irq), 1);
            end
            if (f) begin
                do_ack();
                chk("R8 ack clears", 32'(irq), 0);
            end else begin
                repeat (10) step();
                chk("R6 behind value no fire", 32'(irq), 0);
            end
        end

        // R6: a value equal to the low bits fires only after a full wrap
        wr_rel(0);
        repeat (255) step();
        chk("R6 no fire before wrap", 32'(irq), 0);
        step();
        chk("R6 fire after wrap", 32'(irq), 1);
        do_ack();

        // R9: write in the matching cycle still records the match
        wr_rel(3);
        repeat (2) step();
        wr = 1'b1;
        wdata = wdata + CMP_W'(50);
        step();
        wr = 1'b0;
        chk("R9 match with write", 32'(irq), 1);

        // R10: write while pending keeps it
        wr_rel(3);
        chk("R10 pending after write", 32'(irq), 1);
        // R8: acknowledge in a matching cycle loses to the match
        repeat (2) step();
        do_ack();
        chk("R8 ack vs match", 32'(irq), 1);
        do_ack();
        chk("R8 ack after", 32'(irq), 0);
        do_ack();
        chk("R8 ack idle no effect", 32'(irq), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule